// File: doc/BRIEF.md
# Edge/Level Interrupt Collector

This block gathers up to thirty-two interrupt lines into one request for a processor. The lower sixteen lines come from sources on the same clock. They are always sensed on a rising edge at positive polarity. The upper lines come from up to sixteen external sources, which are first passed through a two-flop synchronizer. Each external line has its own polarity and its own edge or level choice, set by two 16-bit parameters.

Every line is first conditioned so that its active state reads as 1. Its sensing mode then decides when the line raises a sticky bit in the status register. Software sees the status word, an enable mask and a pending word, which is status masked by enable. Software clears status bits through a write-one-to-clear acknowledge register. The output request is high while any pending bit is set. The register port is a plain single-cycle port: writes take effect on the clock edge and reads are combinational.

The block has no state machine. An enumerated register selector decodes the port, with one of five values: none, status, pending, enable or acknowledge.

Top module: `eli_irq_ctrl`

## Requirements
- R1: After reset, the status, pending, enable and acknowledge offsets all read zero and `irq_o` is low.
- R2: Pending always reads as status AND enable. `irq_o` is high exactly when pending is nonzero.
- R3: A write to the acknowledge offset (0x3C) clears the status bits that are written as 1 and are currently set. All other status bits are left unchanged.
- R4: If a level-sensed line is still active when it is acknowledged, its status bit remains set after the write.
- R5: The conditioned value of a line is the raw input XOR the inverse of its polarity bit. With polarity 0 the line is active-low, and with polarity 1 it is active-high.
- R6: An edge-sensed line sets its status bit only when its conditioned value goes from 0 to 1. Once set, the bit stays set until it is acknowledged.
- R7: A level-sensed line (edge configuration bit 0) sets its status bit in every cycle in which its conditioned value is 1.
- R8: Lines 0 to 15 are rising-edge, active-high lines regardless of the parameters. External line k is line 16+k.
- R9: The bits in mask 0x40008787 are reserved. They read as zero in status, pending and enable, and can never be set.
- R10: The offsets are 0x30 (status), 0x34 (pending), 0x38 (enable) and 0x3C (acknowledge). Status and pending ignore writes, and acknowledge reads as zero. A write to any other offset, or to an address whose low two bits are not 00, changes nothing.
- R11: An internal line sets its status bit at the first clock edge after it changes. An external line sets its status bit at the third clock edge after it changes.
- R12: When a new edge event and an acknowledge of the same bit happen in the same cycle, the status bit stays set.
- R13: A write to enable changes pending and `irq_o` from the clock edge that takes the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_int_i | input | 16 | Internal interrupt sources, on the block clock |
| irq_ext_i | input | NUM_EXT | External interrupt sources, asynchronous |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest cases to reach from the ports are the ones where a clear and a new set land on the same clock edge. In one, an acknowledge arrives while a level line is still asserted. In the other, an acknowledge arrives in the very cycle that a fresh edge arrives. Because external lines reach the status register three edges late, the stimulus places the acknowledge write relative to that latency: for example, it raises an internal line and writes its acknowledge in the same step. Random input patterns mixed with random enable, acknowledge and stray writes then exercise many overlaps of sets and clears against a cycle-level reference model.

// File: rtl/eli_pkg.sv
package eli_pkg;
    localparam logic [31:0] RSV_MASK = 32'h4000_8787;

    localparam logic [7:0] OFS_STATUS  = 8'h30;
    localparam logic [7:0] OFS_PENDING = 8'h34;
    localparam logic [7:0] OFS_ENABLE  = 8'h38;
    localparam logic [7:0] OFS_ACK     = 8'h3C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_PENDING,
        SEL_ENABLE,
        SEL_ACK
    } reg_sel_e;
endpackage

// File: rtl/eli_sync.sv
module eli_sync #(
    parameter int W = 16,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= d_i;
            stab_q <= meta_q;
        end
    end

    assign q_o = stab_q;
endmodule

// File: rtl/eli_detect.sv
module eli_detect #(
    parameter int N = 32,
    parameter logic [31:0] EDGE_CFG = 32'hFFFF_FFFF,
    parameter logic [31:0] POS_CFG  = 32'hFFFF_FFFF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] evt_o
);
    logic [N-1:0] cond;
    logic [N-1:0] prev_q;
    logic         past_ok;

    for (genvar i = 0; i < N; i++) begin : g_line
        // a line with polarity 0 is active-low: its idle 1 becomes 0
        assign cond[i] = raw_i[i] ^ ~POS_CFG[i];
        if (EDGE_CFG[i]) begin : g_edge
            assign evt_o[i] = cond[i] & ~prev_q[i];
        end else begin : g_level
            assign evt_o[i] = cond[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= '0;
            past_ok <= 1'b0;
        end else begin
            prev_q  <= cond;
            past_ok <= 1'b1;
        end
    end

    AST_EDGE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((evt_o & $past(evt_o) & EDGE_CFG[N-1:0]) == '0)); // R6
endmodule

// File: rtl/eli_regs.sv
module eli_regs
    import eli_pkg::*;
#(
    parameter int N = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      evt_i,
    input  logic              bus_sel_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              irq_o
);
    localparam logic [31:0] LIVE  = 32'hFFFF_FFFF >> (32 - N);
    localparam logic [31:0] VALID = LIVE & ~RSV_MASK;

    reg_sel_e    sel;
    logic        wr_ok;
    logic [31:0] status_q;
    logic [31:0] enable_q;
    logic [31:0] pending;
    logic [31:0] ack_bits;
    logic [31:0] evt_valid;
    logic        past_ok;

    always_comb begin
        sel = SEL_NONE;
        if (bus_sel_i && bus_addr_i[1:0] == 2'b00) begin
            if (ADDR_W'(OFS_STATUS) == bus_addr_i)       sel = SEL_STATUS;
            else if (ADDR_W'(OFS_PENDING) == bus_addr_i) sel = SEL_PENDING;
            else if (ADDR_W'(OFS_ENABLE) == bus_addr_i)  sel = SEL_ENABLE;
            else if (ADDR_W'(OFS_ACK) == bus_addr_i)     sel = SEL_ACK;
        end
    end

    assign wr_ok     = bus_sel_i && bus_we_i;
    assign ack_bits  = (wr_ok && sel == SEL_ACK) ? bus_wdata_i : '0;
    assign evt_valid = 32'(evt_i) & VALID;
    assign pending   = status_q & enable_q;
    assign irq_o     = |pending;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            enable_q <= '0;
            past_ok  <= 1'b0;
        end else begin
            // the new event is ORed in after the clear, so it wins
            status_q <= (status_q & ~(ack_bits & status_q)) | evt_valid;
            if (wr_ok && sel == SEL_ENABLE) enable_q <= bus_wdata_i & VALID;
            past_ok <= 1'b1;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_STATUS:  bus_rdata_o = status_q;
            SEL_PENDING: bus_rdata_o = pending;
            SEL_ENABLE:  bus_rdata_o = enable_q;
            SEL_ACK:     bus_rdata_o = '0;
            SEL_NONE:    bus_rdata_o = '0;
            default:     bus_rdata_o = '0;
        endcase
    end

    AST_RSV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q | enable_q) & RSV_MASK) == '0); // R9
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_bits != '0) |=> ((status_q & $past(ack_bits & ~evt_valid)) == '0)); // R3
    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((status_q & $past(evt_valid)) == $past(evt_valid))); // R12
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ($past(ack_bits) != '0 || (status_q & $past(status_q)) == $past(status_q))); // R6
endmodule

// File: rtl/eli_irq_ctrl.sv
module eli_irq_ctrl #(
    parameter int NUM_EXT = 16,
    parameter logic [15:0] EXT_EDGE_CFG = 16'h0000,
    parameter logic [15:0] EXT_POS_CFG  = 16'h0000,
    parameter int ADDR_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [15:0]        irq_int_i,
    input  logic [NUM_EXT-1:0] irq_ext_i,
    input  logic               bus_sel_i,
    input  logic               bus_we_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [31:0]        bus_wdata_i,
    output logic [31:0]        bus_rdata_o,
    output logic               irq_o
);
    localparam int N = 16 + NUM_EXT;
    localparam logic [31:0] EDGE_FULL = {EXT_EDGE_CFG, 16'hFFFF};
    localparam logic [31:0] POS_FULL  = {EXT_POS_CFG, 16'hFFFF};
    localparam logic [NUM_EXT-1:0] EXT_IDLE = ~EXT_POS_CFG[NUM_EXT-1:0];

    logic [NUM_EXT-1:0] ext_sync;
    logic [N-1:0]       evt;

    eli_sync #(.W(NUM_EXT), .RST_VAL(EXT_IDLE)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (irq_ext_i),
        .q_o   (ext_sync)
    );

    eli_detect #(.N(N), .EDGE_CFG(EDGE_FULL), .POS_CFG(POS_FULL)) u_detect (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i ({ext_sync, irq_int_i}),
        .evt_o (evt)
    );

    eli_regs #(.N(N), .ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt),
        .bus_sel_i   (bus_sel_i),
        .bus_we_i    (bus_we_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .irq_o       (irq_o)
    );
endmodule

// File: tb/eli_irq_ctrl_tb.sv
module eli_irq_ctrl_tb;
    localparam logic [15:0] T_EDGE = 16'h00FF;
    localparam logic [15:0] T_POS  = 16'h0F0F;
    localparam logic [31:0] EDGE_F = {T_EDGE, 16'hFFFF};
    localparam logic [31:0] POS_F  = {T_POS, 16'hFFFF};
    localparam logic [31:0] VALID  = 32'hBFFF_7878;
    localparam logic [15:0] EXT_IDLE = ~T_POS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_int = '0;
    logic [15:0] irq_ext = EXT_IDLE;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    logic [31:0] m_status, m_enable, m_prev;
    logic [15:0] m_s1, m_s2;

    always #5 clk = ~clk;

    eli_irq_ctrl #(.NUM_EXT(16), .EXT_EDGE_CFG(T_EDGE), .EXT_POS_CFG(T_POS), .ADDR_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_int_i(irq_int), .irq_ext_i(irq_ext),
        .bus_sel_i(bus_sel), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .irq_o(irq)
    );

    function automatic logic [31:0] cond_of(input logic [31:0] raw);
        return raw ^ ~POS_F;
    endfunction

    function automatic logic [31:0] evt_of(input logic [31:0] c, input logic [31:0] p);
        return (EDGE_F & c & ~p) | (~EDGE_F & c);
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic model_reset();
        m_status = '0; m_enable = '0; m_prev = '0;
        m_s1 = EXT_IDLE; m_s2 = EXT_IDLE;
    endtask

    // one clock: drive at negedge, update model after posedge
    task automatic step(input logic [15:0] iv, input logic [15:0] ev,
                        input bit wr, input logic [7:0] a, input logic [31:0] d);
        logic [31:0] c, e, ack;
        @(negedge clk);
        irq_int = iv; irq_ext = ev;
        bus_sel = wr; bus_we = wr; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        c   = cond_of({m_s2, iv});
        e   = evt_of(c, m_prev);
        ack = (wr && a == 8'h3C) ? d : '0;
        m_status = (m_status & ~ack) | (e & VALID);
        if (wr && a == 8'h38) m_enable = d & VALID;
        m_prev = c; m_s2 = m_s1; m_s1 = ev;
        #1;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic verify(input string req);
        logic [31:0] v;
        rd(8'h30, v); chk(req, v, m_status);
        rd(8'h34, v); chk(req, v, m_status & m_enable);
        chk(req, 32'(irq), 32'(|(m_status & m_enable)));
        bus_sel = 1'b0;
    endtask

    task automatic idle(input logic [15:0] iv, input logic [15:0] ev);
        step(iv, ev, 1'b0, 8'h00, '0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                bad++; total++;
                $display("FAIL watchdog: got %0d expected below 100000 cycles", cycles);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] v;
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        rd(8'h30, v); chk("R1", v, 0);
        rd(8'h34, v); chk("R1", v, 0);
        rd(8'h38, v); chk("R1", v, 0);
        rd(8'h3C, v); chk("R1", v, 0);
        chk("R1", 32'(irq), 0);
        bus_sel = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        idle(16'h0, EXT_IDLE); idle(16'h0, EXT_IDLE);
        verify("R1");

        // R8/R11: internal line 3 appears at the first edge
        step(16'h0008, EXT_IDLE, 0, 0, 0);
        rd(8'h30, v); chk("R11", v, 32'h8); bus_sel = 0;
        idle(16'h0, EXT_IDLE);
        rd(8'h30, v); chk("R6", v, 32'h8); bus_sel = 0;
        chk("R13", 32'(irq), 0);
        step(16'h0, EXT_IDLE, 1, 8'h38, 32'h8);
        chk("R13", 32'(irq), 1);
        verify("R2");

        // R3: ack a clear bit leaves status, then ack bit 3
        step(16'h0, EXT_IDLE, 1, 8'h3C, 32'h10);
        rd(8'h30, v); chk("R3", v, 32'h8); bus_sel = 0;
        step(16'h0, EXT_IDLE, 1, 8'h3C, 32'hFFFF_FFFF);
        rd(8'h30, v); chk("R3", v, 32'h0); bus_sel = 0;
        chk("R2", 32'(irq), 0);

        // R7/R11: external level line 24 (ext bit 8, active-high)
        step(16'h0, EXT_IDLE | 16'h0100, 0, 0, 0);
        idle(16'h0, EXT_IDLE | 16'h0100);
        rd(8'h30, v); chk("R11", v, 32'h0); bus_sel = 0;
        idle(16'h0, EXT_IDLE | 16'h0100);
        rd(8'h30, v); chk("R7", v, 32'h0100_0000); bus_sel = 0;
        // R4: ack while still active stays set
        step(16'h0, EXT_IDLE | 16'h0100, 1, 8'h3C, 32'h0100_0000);
        rd(8'h30, v); chk("R4", v, 32'h0100_0000); bus_sel = 0;
        repeat (3) idle(16'h0, EXT_IDLE);
        step(16'h0, EXT_IDLE, 1, 8'h3C, 32'h0100_0000);
        rd(8'h30, v); chk("R4", v, 32'h0); bus_sel = 0;

        // R5: line 20 (ext bit 4) is active-low edge
        step(16'h0, EXT_IDLE & ~16'h0010, 0, 0, 0);
        repeat (2) idle(16'h0, EXT_IDLE & ~16'h0010);
        rd(8'h30, v); chk("R5", v, 32'h0010_0000); bus_sel = 0;
        step(16'h0, EXT_IDLE & ~16'h0010, 1, 8'h3C, 32'h0010_0000);
        repeat (3) idle(16'h0, EXT_IDLE);
        rd(8'h30, v); chk("R6", v, 32'h0); bus_sel = 0;

        // R8: internal line held high fires once only
        step(16'h0010, EXT_IDLE, 0, 0, 0);
        step(16'h0010, EXT_IDLE, 1, 8'h3C, 32'h10);
        idle(16'h0010, EXT_IDLE);
        rd(8'h30, v); chk("R8", v, 32'h0); bus_sel = 0;

        // R9: reserved bits
        step(16'h0, EXT_IDLE, 1, 8'h38, 32'hFFFF_FFFF);
        rd(8'h38, v); chk("R9", v, 32'hBFFF_7878); bus_sel = 0;
        step(16'h0001, EXT_IDLE, 0, 0, 0);
        rd(8'h30, v); chk("R9", v, 32'h0); bus_sel = 0;

        // R10: writes to status, misaligned and other offsets ignored
        step(16'h0, EXT_IDLE, 1, 8'h30, 32'hFFFF_FFFF);
        step(16'h0, EXT_IDLE, 1, 8'h39, 32'h0);
        step(16'h0, EXT_IDLE, 1, 8'h20, 32'h0);
        rd(8'h30, v); chk("R10", v, 32'h0);
        rd(8'h38, v); chk("R10", v, 32'hBFFF_7878);
        rd(8'h3C, v); chk("R10", v, 32'h0); bus_sel = 0;

        // R12: new edge and ack of same bit in one cycle
        step(16'h0020, EXT_IDLE, 0, 0, 0);
        idle(16'h0, EXT_IDLE);
        step(16'h0020, EXT_IDLE, 1, 8'h3C, 32'h20);
        rd(8'h30, v); chk("R12", v, 32'h20); bus_sel = 0;
        verify("R12");

        // random mix against the model
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            logic [7:0]  a;
            r = $urandom;
            case (r[2:0])
                3'd0: a = 8'h30;
                3'd1: a = 8'h34;
                3'd2, 3'd3: a = 8'h38;
                3'd4, 3'd5: a = 8'h3C;
                3'd6: a = 8'h3A;
                default: a = 8'h24;
            endcase
            step(16'($urandom), 16'($urandom), r[5:3] == 3'd0 || r[5:3] == 3'd1, a, $urandom);
            verify("R2");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule